// File: doc/BRIEF.md
# Twelve-Pin GPIO Block with Latched Level Interrupts

This block gives software control of twelve general-purpose pins through a small word-addressed register bus. Each pin has an output value and an output-drive enable, and its input level is sampled through a two-stage synchronizer so that software and the interrupt logic see a clean value.

Every pin can raise an interrupt on a level, high or low, chosen per pin. Once a pin sits at its active level its status bit latches and stays set after the level goes away, until software writes a one to that bit. A write of one while the pin is still at its active level leaves the bit set, so the handler must remove the cause before acknowledging. Per-pin enable bits gate the latched status into a single registered interrupt line. A 32-bit routing word is held for the surrounding pad logic but has no effect inside the block.

The register bus carries no data stream and has no back-pressure: a write with `bus_sel` and `bus_wr` high is taken at the next rising clock edge, and `bus_rdata` follows `bus_addr` combinationally in the same cycle while `bus_sel` is high.

Top module: `gpio_lvl_top`

## Requirements
- R1: After reset, every register reads zero, `pin_out` and `pin_oe` are zero and `irq_out` is low.
- R2: Offset 0x00 holds the output values and offset 0x04 the output enables; bits 11:0 drive `pin_out` and `pin_oe` directly, and bits 31:12 read as zero.
- R3: Offset 0x08 returns the pin inputs after two clock edges of synchronization in bits 11:0 (zero above); writes to it have no effect.
- R4: Polarity of pin p (0..7) is bit 4*p of offset 0x10, and of pin p (8..11) is bit 4*(p-8) of offset 0x18; all other bits of both words ignore writes and read zero.
- R5: With polarity 0 a pin is active while high, with polarity 1 while low; its status bit (offset 0x0C, bit p) is set at the clock edge after the synchronized level becomes active, three edges after the pin changes.
- R6: A set status bit stays set after the pin leaves its active level; writing 1 to it clears it at that edge, and writing 0 to it has no effect.
- R7: Writing 1 to a status bit while its pin is still at the active level leaves the bit set.
- R8: Offset 0x14 bit p enables pin p; `irq_out` is a register that, one edge later, is high when any status bit and its enable bit are both 1; status latches whatever the enable.
- R9: Offset 0x1C is a full 32-bit read/write word with no effect on pins, status or interrupt.
- R10: Addresses other than the eight word offsets above (including those with bits 1:0 non-zero) ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, zero when `bus_sel` is low |
| pin_in | input | 12 | Raw pin levels, asynchronous |
| pin_out | output | 12 | Output values to the pads |
| pin_oe | output | 12 | Output-drive enables to the pads |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The embedded properties watch the status latch every cycle: an active level always sets its bit, a set bit never drops without an acknowledge, an acknowledge during an active level never drops it, and the interrupt line never rises with no enabled status behind it and always follows an enabled one. Zero reads of unused bits and unmapped addresses are also checked each cycle. The exact three-edge latency from pin to status, the placement of polarity bits at every fourth position across the two type words, the inertness of the routing word and the writes that must be ignored can only be shown by the directed scenarios reading back through the bus.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;

  // Word offsets; fixed by the software view of the block.
  localparam logic [7:0] OFS_DOUT   = 8'h00;
  localparam logic [7:0] OFS_OE     = 8'h04;
  localparam logic [7:0] OFS_LEVEL  = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h0C;
  localparam logic [7:0] OFS_POLA   = 8'h10;
  localparam logic [7:0] OFS_ENABLE = 8'h14;
  localparam logic [7:0] OFS_POLB   = 8'h18;
  localparam logic [7:0] OFS_ROUTE  = 8'h1C;

  // Polarity packing: pins per type word and spacing between their bits.
  localparam int PINS_PER_POL_WORD = 8;
  localparam int POL_BIT_STRIDE    = 4;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DOUT, SEL_OE, SEL_LEVEL, SEL_STATUS,
    SEL_POLA, SEL_ENABLE, SEL_POLB, SEL_ROUTE
  } reg_sel_e;

endpackage

// File: rtl/gpio_lvl_sync.sv
module gpio_lvl_sync #(
  parameter int WIDTH  = 12,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_lvl_irq.sv
module gpio_lvl_irq #(
  parameter int NUM_PINS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] level,
  input  logic [NUM_PINS-1:0] polarity,
  input  logic [NUM_PINS-1:0] enable,
  input  logic [NUM_PINS-1:0] ack,
  output logic [NUM_PINS-1:0] status,
  output logic                irq
);

  logic [NUM_PINS-1:0] active;

  // Polarity 1 inverts the level so that low becomes the active state.
  assign active = level ^ polarity;

  // Set dominates acknowledge: a still-active source re-latches at once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status & ~ack) | active;
      irq    <= |(status & enable);
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      active[p] |=> status[p]);                                   // R5
    AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (status[p] && !ack[p]) |=> status[p]);                      // R6
    AST_ACK_DURING_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[p] && active[p]) |=> status[p]);                       // R7
    AST_ENABLED_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      (status[p] && enable[p]) |=> irq);                          // R8
  end

  AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & enable) == '0) |=> !irq);                          // R8

endmodule

// File: rtl/gpio_lvl_regs.sv
module gpio_lvl_regs
  import gpio_lvl_pkg::*;
#(
  parameter int NUM_PINS = 12,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] level,
  input  logic [NUM_PINS-1:0] status,
  output logic [NUM_PINS-1:0] dout,
  output logic [NUM_PINS-1:0] oe,
  output logic [NUM_PINS-1:0] polarity,
  output logic [NUM_PINS-1:0] enable,
  output logic [NUM_PINS-1:0] ack
);

  localparam int PAD_W = DATA_W - NUM_PINS;

  reg_sel_e          sel;
  logic              wr_stb;
  logic [DATA_W-1:0] route_q;
  logic [DATA_W-1:0] pola_word;
  logic [DATA_W-1:0] polb_word;

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFS_DOUT):   sel = SEL_DOUT;
      ADDR_W'(OFS_OE):     sel = SEL_OE;
      ADDR_W'(OFS_LEVEL):  sel = SEL_LEVEL;
      ADDR_W'(OFS_STATUS): sel = SEL_STATUS;
      ADDR_W'(OFS_POLA):   sel = SEL_POLA;
      ADDR_W'(OFS_ENABLE): sel = SEL_ENABLE;
      ADDR_W'(OFS_POLB):   sel = SEL_POLB;
      ADDR_W'(OFS_ROUTE):  sel = SEL_ROUTE;
      default:             sel = SEL_NONE;
    endcase
  end

  assign wr_stb = bus_sel && bus_wr;

  // Acknowledge pulses only in the cycle of a status write.
  assign ack = (wr_stb && sel == SEL_STATUS) ? bus_wdata[NUM_PINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      oe       <= '0;
      enable   <= '0;
      polarity <= '0;
      route_q  <= '0;
    end else if (wr_stb) begin
      case (sel)
        SEL_DOUT:   dout    <= bus_wdata[NUM_PINS-1:0];
        SEL_OE:     oe      <= bus_wdata[NUM_PINS-1:0];
        SEL_ENABLE: enable  <= bus_wdata[NUM_PINS-1:0];
        SEL_ROUTE:  route_q <= bus_wdata;
        SEL_POLA: begin
          for (int p = 0; p < NUM_PINS; p++)
            if (p < PINS_PER_POL_WORD)
              polarity[p] <= bus_wdata[POL_BIT_STRIDE*p];
        end
        SEL_POLB: begin
          for (int p = 0; p < NUM_PINS; p++)
            if (p >= PINS_PER_POL_WORD)
              polarity[p] <= bus_wdata[POL_BIT_STRIDE*(p-PINS_PER_POL_WORD)];
        end
        default: ;
      endcase
    end
  end

  // Spread the packed polarity bits back to every fourth bit position.
  always_comb begin
    pola_word = '0;
    polb_word = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (p < PINS_PER_POL_WORD)
        pola_word[POL_BIT_STRIDE*p] = polarity[p];
      else
        polb_word[POL_BIT_STRIDE*(p-PINS_PER_POL_WORD)] = polarity[p];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (sel)
        SEL_DOUT:   bus_rdata = {{PAD_W{1'b0}}, dout};
        SEL_OE:     bus_rdata = {{PAD_W{1'b0}}, oe};
        SEL_LEVEL:  bus_rdata = {{PAD_W{1'b0}}, level};
        SEL_STATUS: bus_rdata = {{PAD_W{1'b0}}, status};
        SEL_POLA:   bus_rdata = pola_word;
        SEL_ENABLE: bus_rdata = {{PAD_W{1'b0}}, enable};
        SEL_POLB:   bus_rdata = polb_word;
        SEL_ROUTE:  bus_rdata = route_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  AST_UNMAPPED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0));                         // R10
  AST_OUT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_DOUT || sel == SEL_OE) |-> (bus_rdata[DATA_W-1:NUM_PINS] == '0)); // R2
  AST_ACK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> (ack == '0));                                         // R6

endmodule

// File: rtl/gpio_lvl_top.sv
module gpio_lvl_top #(
  parameter int NUM_PINS    = 12,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_out
);

  logic [NUM_PINS-1:0] level_s;
  logic [NUM_PINS-1:0] status_q;
  logic [NUM_PINS-1:0] pol_q;
  logic [NUM_PINS-1:0] en_q;
  logic [NUM_PINS-1:0] ack_p;

  gpio_lvl_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pin_in),
    .q_sync  (level_s)
  );

  gpio_lvl_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .level     (level_s),
    .status    (status_q),
    .dout      (pin_out),
    .oe        (pin_oe),
    .polarity  (pol_q),
    .enable    (en_q),
    .ack       (ack_p)
  );

  gpio_lvl_irq #(.NUM_PINS(NUM_PINS)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .level    (level_s),
    .polarity (pol_q),
    .enable   (en_q),
    .ack      (ack_p),
    .status   (status_q),
    .irq      (irq_out)
  );

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(status_q != '0));                       // R8

endmodule

// File: tb/sim_gpio_lvl_top.sv
`timescale 1ns/1ps
module sim_gpio_lvl_top;

  localparam logic [7:0] A_OUT = 8'h00, A_OE = 8'h04, A_IN = 8'h08, A_ST = 8'h0C;
  localparam logic [7:0] A_T0 = 8'h10, A_EN = 8'h14, A_T1 = 8'h18, A_MUX = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [11:0] pin_in = '0;
  logic [11:0] pin_out;
  logic [11:0] pin_oe;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  gpio_lvl_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    @(negedge clk);
    rd_chk("R1 out", A_OUT, 0);   rd_chk("R1 oe", A_OE, 0);
    rd_chk("R1 st", A_ST, 0);     rd_chk("R1 t0", A_T0, 0);
    rd_chk("R1 en", A_EN, 0);     rd_chk("R1 t1", A_T1, 0);
    rd_chk("R1 mux", A_MUX, 0);
    check("R1 pins", {8'd0, pin_oe, pin_out}, 0);
    check("R1 irq", {31'd0, irq_out}, 0);
  endtask

  task automatic t_outputs();
    wr(A_OUT, 32'hFFFF_FFFF);
    rd_chk("R2 out readback", A_OUT, 32'h0000_0FFF);
    check("R2 pin_out", {20'd0, pin_out}, 32'hFFF);
    wr(A_OE, 32'h1234_50A5);
    rd_chk("R2 oe readback", A_OE, 32'h0000_00A5);
    check("R2 pin_oe", {20'd0, pin_oe}, 32'h0A5);
    wr(A_OUT, 32'h0000_0C3A);
    check("R2 pin_out pattern", {20'd0, pin_out}, 32'hC3A);
  endtask

  task automatic t_input();
    @(negedge clk);
    pin_in = 12'h5A3;
    @(negedge clk);
    rd_chk("R3 one edge not yet", A_IN, 32'h0);
    @(negedge clk);
    rd_chk("R3 two edges", A_IN, 32'h5A3);
    wr(A_IN, 32'hFFFF_FFFF);
    rd_chk("R3 write ignored", A_IN, 32'h5A3);
    @(negedge clk);
    pin_in = '0;
    repeat (3) @(negedge clk);
    wr(A_ST, 32'hFFF);
    rd_chk("R6 cleared", A_ST, 0);
  endtask

  task automatic t_polarity_map();
    wr(A_T0, 32'hFFFF_FFFF);
    rd_chk("R4 type0 bits", A_T0, 32'h1111_1111);
    wr(A_T1, 32'hFFFF_FFFF);
    rd_chk("R4 type1 bits", A_T1, 32'h0000_1111);
    wr(A_T0, 32'h0);
    wr(A_T1, 32'h0);
    rd_chk("R4 type0 clear", A_T0, 0);
    wr(A_ST, 32'hFFF);
    rd_chk("R6 clear all", A_ST, 0);
  endtask

  task automatic t_active_high();
    @(negedge clk);
    pin_in[3] = 1'b1;
    repeat (2) @(negedge clk);
    rd_chk("R5 not before third edge", A_ST, 0);
    @(negedge clk);
    rd_chk("R5 set on third edge", A_ST, 32'h008);
    pin_in[3] = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R6 latched after level gone", A_ST, 32'h008);
    wr(A_ST, 32'h0);
    rd_chk("R6 write zero no effect", A_ST, 32'h008);
    wr(A_ST, 32'h008);
    rd_chk("R6 write one clears", A_ST, 0);
  endtask

  task automatic t_active_low();
    // pin 9 is low; polarity bit 4 of type word 1 makes it active
    wr(A_T1, 32'h0000_0010);
    @(negedge clk);
    rd_chk("R5 active-low pin9", A_ST, 32'h200);
    wr(A_ST, 32'h200);
    rd_chk("R7 ack while active stays", A_ST, 32'h200);
    pin_in[9] = 1'b1;
    repeat (3) @(negedge clk);
    wr(A_ST, 32'h200);
    rd_chk("R7 ack after level gone", A_ST, 0);
    // pin 2 through type word 0 bit 8
    wr(A_T0, 32'h0000_0100);
    @(negedge clk);
    rd_chk("R4 pin2 polarity bit 8", A_ST, 32'h004);
    wr(A_T0, 32'h0);
    wr(A_T1, 32'h0);
    pin_in[9] = 1'b0;
    repeat (3) @(negedge clk);
    wr(A_ST, 32'hFFF);
    rd_chk("R6 clean", A_ST, 0);
  endtask

  task automatic t_irq();
    @(negedge clk);
    pin_in[5] = 1'b1;
    repeat (4) @(negedge clk);
    rd_chk("R8 latch while masked", A_ST, 32'h020);
    check("R8 masked irq low", {31'd0, irq_out}, 0);
    wr(A_EN, 32'h0000_0020);
    check("R8 irq one edge after enable", {31'd0, irq_out}, 0);
    @(negedge clk);
    check("R8 irq high", {31'd0, irq_out}, 1);
    rd_chk("R8 enable readback", A_EN, 32'h020);
    pin_in[5] = 1'b0;
    repeat (3) @(negedge clk);
    wr(A_ST, 32'h020);
    check("R8 irq lags clear", {31'd0, irq_out}, 1);
    @(negedge clk);
    check("R8 irq low after clear", {31'd0, irq_out}, 0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_mux();
    logic [11:0] po, pe;
    po = pin_out; pe = pin_oe;
    wr(A_MUX, 32'hDEAD_BEEF);
    rd_chk("R9 mux readback", A_MUX, 32'hDEAD_BEEF);
    check("R9 pins untouched", {8'd0, pin_oe, pin_out}, {8'd0, pe, po});
    @(negedge clk);
    rd_chk("R9 status untouched", A_ST, 0);
    check("R9 irq untouched", {31'd0, irq_out}, 0);
  endtask

  task automatic t_unmapped();
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    rd_chk("R10 read 0x20", 8'h20, 0);
    rd_chk("R10 read 0x02", 8'h02, 0);
    rd_chk("R10 out unchanged", A_OUT, 32'hC3A);
    rd_chk("R10 en unchanged", A_EN, 0);
    rd_chk("R10 mux unchanged", A_MUX, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_outputs();
    t_input();
    t_polarity_map();
    t_active_high();
    t_active_low();
    t_irq();
    t_mux();
    t_unmapped();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule